// File: doc/BRIEF.md
# Serial Audio Port Routing Matrix

This block is a configurable crossbar for a group of synchronous serial audio ports. Each port has four timing pins: a transmit-side clock, a transmit-side frame sync, a receive-side clock and a receive-side frame sync. It also has two data pins, A and B. Software writes two control words per port through a simple one-cycle write bus. The timing word picks where each of the port's clock and frame-sync pins gets its signal and whether the block drives that pin. The data word picks where the port's receive data comes from, whether pins A and B trade roles, and whether the receive data is a masked wired-AND of several ports (network mode).

All routing is combinational from the pad inputs to the pad outputs. This lets bit clocks and frame syncs pass through without being resampled. Only the control words are stored. A per-port clear input wipes one port's configuration. A chip reset loads the synchronous-mode default. A third, shared word is stored for software use and has no routing effect.

Top module: `aud_route_xbar`

## Requirements
- R1: After reset, every port's timing word reads 0x0000_0800 (bit 11, synchronous mode, set). Every port's data word reads zero, and the shared word at offset 0x38 reads zero.
- R2: Port n's timing word sits at byte offset 8n and its data word at 8n+4. The shared word at 0x38 stores all 32 bits. A timing word keeps bits 31:11 and reads zero in bits 10:0. A data word keeps bits 15:12 and 9:0 and reads zero elsewhere. Offsets with bits 1:0 non-zero, offset 0x3C, and offsets of ports at or above NPORT read zero, and writes to them change nothing.
- R3: Holding port_clr[n] for one clock sets both of port n's words to zero on that edge, including the synchronous bit. Other ports keep their words.
- R4: The timing word holds four 4-bit source fields: receive clock 15:12, receive frame sync 20:17, transmit clock 25:22, transmit frame sync 30:27. In a field, bits 2:0 give the source port number. Bit 3 set takes that port's receive-side input (rck_i for clocks, rfs_i for frame syncs); bit 3 clear takes its transmit-side input (tck_i, tfs_i). A port number at or above NPORT yields 0.
- R5: Direction bits 16, 21, 26 and 31 belong to the receive clock, receive frame sync, transmit clock and transmit frame sync. A 1 raises the pin's enable and drives the routed value. A 0 drops the enable and holds the output at 0.
- R6: With bit 11 set, the receive clock and receive frame-sync pins carry the transmit clock and transmit frame-sync routed values and enables. The receive source and direction fields are then ignored.
- R7: In the data word, bits 9:8 are the mode. For any mode other than 1, the port's receive data is the transmit data of the port named in bits 15:13, or 0 if that number is at or above NPORT. A port's transmit data is its pin A input, or its pin B input when that port's swap bit 12 is set.
- R8: With swap bit 12 clear, pin A is an input (enable 0, output 0) and pin B drives the receive data with its enable at 1. With bit 12 set, the roles are exchanged.
- R9: In mode 1, the receive data is the AND of the transmit data of every port k below NPORT whose mask bit k (bits 7:0) is 0. It is 1 when no port is included. Mask bits at or above NPORT have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per word |
| wr_addr | input | 6 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Byte offset of the read |
| rd_data | output | 32 | Stored word at rd_addr (combinational) |
| port_clr | input | NPORT | Per-port configuration clear |
| tck_i | input | NPORT | Transmit-side clock pad inputs |
| tfs_i | input | NPORT | Transmit-side frame-sync pad inputs |
| rck_i | input | NPORT | Receive-side clock pad inputs |
| rfs_i | input | NPORT | Receive-side frame-sync pad inputs |
| pina_i | input | NPORT | Data pin A pad inputs |
| pinb_i | input | NPORT | Data pin B pad inputs |
| tck_o | output | NPORT | Transmit-side clock outputs |
| tck_oe | output | NPORT | Transmit-side clock enables |
| tfs_o | output | NPORT | Transmit-side frame-sync outputs |
| tfs_oe | output | NPORT | Transmit-side frame-sync enables |
| rck_o | output | NPORT | Receive-side clock outputs |
| rck_oe | output | NPORT | Receive-side clock enables |
| rfs_o | output | NPORT | Receive-side frame-sync outputs |
| rfs_oe | output | NPORT | Receive-side frame-sync enables |
| pina_o | output | NPORT | Data pin A outputs |
| pina_oe | output | NPORT | Data pin A enables |
| pinb_o | output | NPORT | Data pin B outputs |
| pinb_oe | output | NPORT | Data pin B enables |

## Verification
The bench builds the matrix with NPORT = 4. Source numbers 4 to 7 then still fit the 3-bit port fields, so every out-of-range source and every empty port offset (0x20 to 0x37) can be reached. With four ports, the bench can sweep all sixteen selector codes of every port against all 256 combinations of transmit-side and receive-side pad inputs. It can also sweep every combination of the four swap bits against each direct source, and all 256 mask values, including the ignored upper bits and the all-excluded case, against every data pattern.

// File: rtl/aud_xbar_pkg.sv
`timescale 1ns/1ps
package aud_xbar_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 3;
    localparam int SPAN   = 1 << IDX_W;
    localparam int MASK_W = 8;

    localparam logic [ADDR_W-1:0] SHARED_OFS = 6'h38;
    localparam logic [WORD_W-1:0] TIM_RESET  = 32'h0000_0800;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_NET    = 2'd1,
        MODE_RSV2   = 2'd2,
        MODE_RSV3   = 2'd3
    } rx_mode_e;

    typedef struct packed {
        logic             from_rx;
        logic [IDX_W-1:0] port;
    } sel_t;

    typedef struct packed {
        logic        tfs_drv;
        sel_t        tfs_src;
        logic        tck_drv;
        sel_t        tck_src;
        logic        rfs_drv;
        sel_t        rfs_src;
        logic        rck_drv;
        sel_t        rck_src;
        logic        sync_en;
        logic [10:0] rsvd;
    } timing_w_t;

    typedef struct packed {
        logic [15:0]       rsvd_hi;
        logic [IDX_W-1:0]  rxd_src;
        logic              swap;
        logic [1:0]        rsvd_mid;
        rx_mode_e          mode;
        logic [MASK_W-1:0] excl_mask;
    } data_w_t;

    function automatic timing_w_t tim_keep(logic [WORD_W-1:0] w);
        timing_w_t t;
        t = timing_w_t'(w);
        t.rsvd = '0;
        return t;
    endfunction

    function automatic data_w_t dat_keep(logic [WORD_W-1:0] w);
        data_w_t d;
        d = data_w_t'(w);
        d.rsvd_hi  = '0;
        d.rsvd_mid = '0;
        return d;
    endfunction

    function automatic logic pick_src(sel_t s, logic [SPAN-1:0] txv, logic [SPAN-1:0] rxv);
        return s.from_rx ? rxv[s.port] : txv[s.port];
    endfunction

endpackage

// File: rtl/aud_xbar_regs.sv
`timescale 1ns/1ps
module aud_xbar_regs
    import aud_xbar_pkg::*;
#(
    parameter int NPORT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NPORT-1:0]  port_clr,
    output logic [WORD_W-1:0] rd_data,
    output timing_w_t         tim_q [NPORT],
    output data_w_t           dat_q [NPORT]
);

    localparam int ROW_LSB = 3;

    logic [WORD_W-1:0] shared_q;
    logic              wr_ok;
    logic [IDX_W-1:0]  wr_row;

    assign wr_ok  = wr_en && (wr_addr[1:0] == 2'b00);
    assign wr_row = wr_addr[ADDR_W-1:ROW_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPORT; p++) begin
                tim_q[p] <= timing_w_t'(TIM_RESET);
                dat_q[p] <= '0;
            end
            shared_q <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (port_clr[p]) begin
                    tim_q[p] <= '0;
                    dat_q[p] <= '0;
                end else if (wr_ok && wr_row == IDX_W'(p)) begin
                    if (wr_addr[2]) dat_q[p] <= dat_keep(wr_data);
                    else            tim_q[p] <= tim_keep(wr_data);
                end
            end
            if (wr_ok && wr_addr == SHARED_OFS) shared_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr[1:0] == 2'b00) begin
            if (rd_addr == SHARED_OFS) begin
                rd_data = shared_q;
            end else begin
                for (int p = 0; p < NPORT; p++) begin
                    if (rd_addr[ADDR_W-1:ROW_LSB] == IDX_W'(p))
                        rd_data = rd_addr[2] ? WORD_W'(dat_q[p]) : WORD_W'(tim_q[p]);
                end
            end
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_clr_chk
        // R3
        port_clear_chk: assert property (@(posedge clk) disable iff (rst)
            port_clr[g] |=> (tim_q[g] == '0 && dat_q[g] == '0));
    end

endmodule

// File: rtl/aud_xbar_port_route.sv
`timescale 1ns/1ps
module aud_xbar_port_route
    import aud_xbar_pkg::*;
#(
    parameter int NPORT = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  timing_w_t       tim,
    input  data_w_t         dat,
    input  logic [SPAN-1:0] tck_x,
    input  logic [SPAN-1:0] tfs_x,
    input  logic [SPAN-1:0] rck_x,
    input  logic [SPAN-1:0] rfs_x,
    input  logic [SPAN-1:0] txd_x,
    output logic            tck_o,
    output logic            tck_oe,
    output logic            tfs_o,
    output logic            tfs_oe,
    output logic            rck_o,
    output logic            rck_oe,
    output logic            rfs_o,
    output logic            rfs_oe,
    output logic            pina_o,
    output logic            pina_oe,
    output logic            pinb_o,
    output logic            pinb_oe
);

    logic tck_v, tfs_v, rck_v, rfs_v;
    logic rck_en, rfs_en;
    logic net_and, rxd_v;
    logic unused_ok;

    assign unused_ok = ^{tim.rsvd, dat.rsvd_hi, dat.rsvd_mid, dat.excl_mask[MASK_W-1:NPORT]};

    // timing selection; synchronous mode reuses the transmit path
    always_comb begin
        tck_v  = pick_src(tim.tck_src, tck_x, rck_x);
        tfs_v  = pick_src(tim.tfs_src, tfs_x, rfs_x);
        rck_v  = tim.sync_en ? tck_v : pick_src(tim.rck_src, tck_x, rck_x);
        rfs_v  = tim.sync_en ? tfs_v : pick_src(tim.rfs_src, tfs_x, rfs_x);
        rck_en = tim.sync_en ? tim.tck_drv : tim.rck_drv;
        rfs_en = tim.sync_en ? tim.tfs_drv : tim.rfs_drv;
    end

    assign tck_oe = tim.tck_drv;
    assign tfs_oe = tim.tfs_drv;
    assign rck_oe = rck_en;
    assign rfs_oe = rfs_en;
    assign tck_o  = tim.tck_drv & tck_v;
    assign tfs_o  = tim.tfs_drv & tfs_v;
    assign rck_o  = rck_en & rck_v;
    assign rfs_o  = rfs_en & rfs_v;

    // masked wired-AND over included ports
    always_comb begin
        net_and = 1'b1;
        for (int k = 0; k < NPORT; k++) begin
            if (!dat.excl_mask[k]) net_and &= txd_x[k];
        end
    end

    assign rxd_v   = (dat.mode == MODE_NET) ? net_and : txd_x[dat.rxd_src];
    assign pina_oe = dat.swap;
    assign pinb_oe = ~dat.swap;
    assign pina_o  = dat.swap & rxd_v;
    assign pinb_o  = ~dat.swap & rxd_v;

    // R6
    sync_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        tim.sync_en |-> (rck_o == tck_o && rfs_o == tfs_o && rck_oe == tck_oe && rfs_oe == tfs_oe));

    // R5
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!tck_oe |-> !tck_o) and (!rfs_oe |-> !rfs_o));

    // R8
    pin_role_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({pina_oe, pinb_oe}) == 1 && !(pina_oe ? pinb_o : pina_o));

    // R9
    net_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (dat.mode == MODE_NET && (&dat.excl_mask[NPORT-1:0])) |-> (pina_oe ? pina_o : pinb_o));

endmodule

// File: rtl/aud_route_xbar.sv
`timescale 1ns/1ps
module aud_route_xbar
    import aud_xbar_pkg::*;
#(
    parameter int NPORT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NPORT-1:0]  port_clr,
    input  logic [NPORT-1:0]  tck_i,
    input  logic [NPORT-1:0]  tfs_i,
    input  logic [NPORT-1:0]  rck_i,
    input  logic [NPORT-1:0]  rfs_i,
    input  logic [NPORT-1:0]  pina_i,
    input  logic [NPORT-1:0]  pinb_i,
    output logic [NPORT-1:0]  tck_o,
    output logic [NPORT-1:0]  tck_oe,
    output logic [NPORT-1:0]  tfs_o,
    output logic [NPORT-1:0]  tfs_oe,
    output logic [NPORT-1:0]  rck_o,
    output logic [NPORT-1:0]  rck_oe,
    output logic [NPORT-1:0]  rfs_o,
    output logic [NPORT-1:0]  rfs_oe,
    output logic [NPORT-1:0]  pina_o,
    output logic [NPORT-1:0]  pina_oe,
    output logic [NPORT-1:0]  pinb_o,
    output logic [NPORT-1:0]  pinb_oe
);

    localparam int PAD_W = SPAN - NPORT;

    timing_w_t        tim_q [NPORT];
    data_w_t          dat_q [NPORT];
    logic [NPORT-1:0] txd_v;
    logic [SPAN-1:0]  tck_x, tfs_x, rck_x, rfs_x, txd_x;

    aud_xbar_regs #(.NPORT(NPORT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .port_clr (port_clr),
        .rd_data  (rd_data),
        .tim_q    (tim_q),
        .dat_q    (dat_q)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_txd
        assign txd_v[g] = dat_q[g].swap ? pinb_i[g] : pina_i[g];
    end

    // widen to the full selector span; absent ports read as 0
    assign tck_x = {{PAD_W{1'b0}}, tck_i};
    assign tfs_x = {{PAD_W{1'b0}}, tfs_i};
    assign rck_x = {{PAD_W{1'b0}}, rck_i};
    assign rfs_x = {{PAD_W{1'b0}}, rfs_i};
    assign txd_x = {{PAD_W{1'b0}}, txd_v};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        aud_xbar_port_route #(.NPORT(NPORT)) u_route (
            .clk     (clk),
            .rst     (rst),
            .tim     (tim_q[g]),
            .dat     (dat_q[g]),
            .tck_x   (tck_x),
            .tfs_x   (tfs_x),
            .rck_x   (rck_x),
            .rfs_x   (rfs_x),
            .txd_x   (txd_x),
            .tck_o   (tck_o[g]),
            .tck_oe  (tck_oe[g]),
            .tfs_o   (tfs_o[g]),
            .tfs_oe  (tfs_oe[g]),
            .rck_o   (rck_o[g]),
            .rck_oe  (rck_oe[g]),
            .rfs_o   (rfs_o[g]),
            .rfs_oe  (rfs_oe[g]),
            .pina_o  (pina_o[g]),
            .pina_oe (pina_oe[g]),
            .pinb_o  (pinb_o[g]),
            .pinb_oe (pinb_oe[g])
        );
    end

endmodule

// File: tb/tb_aud_route_xbar.sv
`timescale 1ns/1ps
module tb_aud_route_xbar;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [5:0]    wr_addr;
    logic [31:0]   wr_data;
    logic [5:0]    rd_addr;
    logic [31:0]   rd_data;
    logic [NP-1:0] port_clr;
    logic [NP-1:0] tck_i, tfs_i, rck_i, rfs_i, pina_i, pinb_i;
    logic [NP-1:0] tck_o, tck_oe, tfs_o, tfs_oe, rck_o, rck_oe, rfs_o, rfs_oe;
    logic [NP-1:0] pina_o, pina_oe, pinb_o, pinb_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    aud_route_xbar #(.NPORT(NP)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .port_clr(port_clr),
        .tck_i(tck_i), .tfs_i(tfs_i), .rck_i(rck_i), .rfs_i(rfs_i),
        .pina_i(pina_i), .pinb_i(pinb_i),
        .tck_o(tck_o), .tck_oe(tck_oe), .tfs_o(tfs_o), .tfs_oe(tfs_oe),
        .rck_o(rck_o), .rck_oe(rck_oe), .rfs_o(rfs_o), .rfs_oe(rfs_oe),
        .pina_o(pina_o), .pina_oe(pina_oe), .pinb_o(pinb_o), .pinb_oe(pinb_oe)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        rd_addr = 6'(a);
        #1;
        check(req, rd_data, exp);
    endtask

    function automatic logic [31:0] mk_tim(int tfd, int tfs, int tcd, int tcs,
                                           int rfd, int rfs, int rcd, int rcs, int syn);
        return (32'(tfd) << 31) | (32'(tfs) << 27) | (32'(tcd) << 26) | (32'(tcs) << 22) |
               (32'(rfd) << 21) | (32'(rfs) << 17) | (32'(rcd) << 16) | (32'(rcs) << 12) |
               (32'(syn) << 11);
    endfunction

    function automatic logic [31:0] mk_dat(int mask, int mode, int swp, int src);
        return 32'(mask) | (32'(mode) << 8) | (32'(swp) << 12) | (32'(src) << 13);
    endfunction

    function automatic logic bpick(int sel, logic [NP-1:0] tx, logic [NP-1:0] rx);
        int p;
        p = sel % 8;
        if (p >= NP) return 1'b0;
        return (sel >= 8) ? rx[p] : tx[p];
    endfunction

    // expected read value of an aligned offset after writing w to it
    function automatic logic [31:0] kept(int a, logic [31:0] w);
        if (a == 'h38) return w;
        if (a >= NP * 8) return 32'h0;
        return (a % 8 == 0) ? (w & 32'hFFFF_F800) : (w & 32'h0000_F3FF);
    endfunction

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] txd;
        logic          exp;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; port_clr = '0;
        tck_i = '0; tfs_i = '0; rck_i = '0; rfs_i = '0; pina_i = '0; pinb_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset contents
        for (int a = 0; a < 64; a += 4)
            rd_chk("R1 reset word", a, (a < NP * 8 && a % 8 == 0) ? 32'h800 : 32'h0);

        // R2 unaligned writes ignored
        for (int a = 0; a < 64; a++)
            if (a % 4 != 0) wr(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 64; a += 4)
            rd_chk("R2 unaligned write ignored", a, (a < NP * 8 && a % 8 == 0) ? 32'h800 : 32'h0);

        // R2 storage of defined fields, two patterns
        for (int a = 0; a < 64; a += 4) wr(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 64; a += 4) rd_chk("R2 all-ones readback", a, kept(a, 32'hFFFF_FFFF));
        for (int a = 1; a < 64; a += 4) rd_chk("R2 unaligned read zero", a, 32'h0);
        for (int a = 0; a < 64; a += 4) wr(a, 32'hA5A5_A5A5);
        for (int a = 0; a < 64; a += 4) rd_chk("R2 pattern readback", a, kept(a, 32'hA5A5_A5A5));

        // R3 per-port clear
        wr(8, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF); wr(16, 32'h1234_5678);
        @(negedge clk); port_clr = 4'b0010;
        @(negedge clk); port_clr = 4'b0000;
        rd_chk("R3 cleared timing", 8, 32'h0);
        rd_chk("R3 cleared data", 12, 32'h0);
        rd_chk("R3 neighbour kept", 16, 32'h1234_5000);
        check("R3 cleared port pin B role", 32'(pinb_oe[1]), 32'h1);

        // R4 R5 selector and direction sweep, asynchronous
        for (int t = 0; t < NP; t++) begin
            for (int s = 0; s < 16; s++) begin
                wr(t * 8, mk_tim(1, s ^ 8, 1, s, 0, s, 1, (s + 3) % 16, 0));
                for (int v = 0; v < 256; v++) begin
                    tck_i = 4'(v); rck_i = 4'(v >> 4);
                    tfs_i = ~4'(v); rfs_i = 4'(v >> 4) ^ 4'h5;
                    #1;
                    check("R4 tck route", 32'(tck_o[t]), 32'(bpick(s, tck_i, rck_i)));
                    check("R4 tfs route", 32'(tfs_o[t]), 32'(bpick(s ^ 8, tfs_i, rfs_i)));
                    check("R4 rck route", 32'(rck_o[t]), 32'(bpick((s + 3) % 16, tck_i, rck_i)));
                    check("R5 released rfs", 32'({rfs_oe[t], rfs_o[t]}), 32'h0);
                    check("R5 driven enables", 32'({tck_oe[t], tfs_oe[t], rck_oe[t]}), 32'h7);
                end
            end
        end

        // R6 synchronous mirror
        for (int t = 0; t < NP; t++) begin
            for (int s = 0; s < 16; s++) begin
                wr(t * 8, mk_tim(0, s, 1, s ^ 8, 1, (s + 5) % 16, 0, (s + 1) % 16, 1));
                for (int v = 0; v < 256; v++) begin
                    tck_i = 4'(v); rck_i = 4'(v >> 4);
                    tfs_i = 4'(v >> 2); rfs_i = ~4'(v);
                    #1;
                    check("R6 rck follows transmit clock", 32'({rck_oe[t], rck_o[t]}),
                          32'({1'b1, bpick(s ^ 8, tck_i, rck_i)}));
                    check("R6 rfs follows released tfs", 32'({rfs_oe[t], rfs_o[t]}), 32'h0);
                end
            end
        end

        // R7 R8 direct routing, every swap combination and reserved modes
        for (int t = 0; t < NP; t++) begin
            for (int src = 0; src < 8; src++) begin
                for (int sw = 0; sw < 16; sw++) begin
                    int md;
                    md = (sw % 4 == 1) ? 2 : ((sw % 4 == 3) ? 3 : 0);
                    for (int q = 0; q < NP; q++)
                        wr(q * 8 + 4, mk_dat(0, (q == t) ? md : 0, (sw >> q) & 1, (q == t) ? src : 0));
                    for (int v = 0; v < 16; v++) begin
                        pina_i = 4'(v);
                        pinb_i = {pina_i[0], pina_i[3:1]} ^ 4'hA;
                        #1;
                        for (int q = 0; q < NP; q++) txd[q] = sw[q] ? pinb_i[q] : pina_i[q];
                        exp = (src < NP) ? txd[src] : 1'b0;
                        if (sw[t]) begin
                            check("R8 swapped roles", 32'({pina_oe[t], pinb_oe[t], pinb_o[t]}), 32'h4);
                            check("R7 rx data on pin A", 32'(pina_o[t]), 32'(exp));
                        end else begin
                            check("R8 default roles", 32'({pinb_oe[t], pina_oe[t], pina_o[t]}), 32'h4);
                            check("R7 rx data on pin B", 32'(pinb_o[t]), 32'(exp));
                        end
                    end
                end
            end
        end

        // R9 network wired-AND over all masks
        for (int t = 0; t < NP; t++) begin
            for (int q = 0; q < NP; q++) wr(q * 8 + 4, 32'h0);
            for (int m = 0; m < 256; m++) begin
                int swt;
                swt = (m >> 5) & 1;
                wr(t * 8 + 4, mk_dat(m, 1, swt, m % 8));
                for (int v = 0; v < 16; v++) begin
                    pina_i = 4'(v);
                    pinb_i = ~{pina_i[2:0], pina_i[3]};
                    #1;
                    for (int q = 0; q < NP; q++)
                        txd[q] = (q == t && swt == 1) ? pinb_i[q] : pina_i[q];
                    exp = 1'b1;
                    for (int k = 0; k < NP; k++)
                        if (!m[k]) exp = exp & txd[k];
                    check("R9 network AND", 32'(swt == 1 ? pina_o[t] : pinb_o[t]), 32'(exp));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule